// File: doc/BRIEF.md
# Ripple Up/Down Counter with Forced Hold

A small ripple counter built from a chain of toggle stages. The first stage toggles on every rising edge of an input clock that passes through a gate. Each later stage is clocked by the output of the stage before it, either directly or inverted. A direction pin picks which, so the same chain counts up or down. Because the carry ripples through the stages, the outputs settle a few gate delays after each input edge and are sampled away from that edge.

Two force pins act directly on the stages' asynchronous reset and set inputs. One loads all zeros and the other loads all ones. While either pin is high, the gate blocks the input clock, so the forced value holds however the input clock runs. The gate uses a latch that is open only while the input clock is low. When the force is released during a high phase of the clock, that high phase is cut off, and counting resumes on the first full rising edge that follows. The default chain has three stages (A, B, C), and stage A is bit 0.

Top module: `ripple_updown_counter`

## Requirements
- R1: While `clear_all` is 1, `count_q` reads 0 at once, with no edge on `clk_in` needed.
- R2: While `preset_all` is 1 and `clear_all` is 0, `count_q` reads all ones (7 for three stages) at once.
- R3: When `clear_all` and `preset_all` are both 1, clearing wins and `count_q` reads 0.
- R4: When `count_up` is 1 and neither force pin is high, each rising edge of `clk_in` adds 1 to `count_q` modulo 2^STAGES, so 7 wraps to 0. Bit 0 (stage A) toggles on every edge.
- R5: When `count_up` is 0 and neither force pin is high, each rising edge of `clk_in` subtracts 1 from `count_q` modulo 2^STAGES, so 0 wraps to 7.
- R6: While either force pin is high, rising edges of `clk_in` leave `count_q` unchanged.
- R7: If a force pin is released while `clk_in` is high, `count_q` does not change during the rest of that high phase. The first step happens on the next rising edge of `clk_in`.
- R8: If `clear_all` falls while `preset_all` stays high, `count_q` goes to all ones without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input count clock; drives stage A through the hold gate |
| count_up | input | 1 | Direction: 1 counts up, 0 counts down |
| clear_all | input | 1 | Asynchronous force to all zeros; blocks the input clock |
| preset_all | input | 1 | Asynchronous force to all ones; blocks the input clock |
| count_q | output | STAGES | Stage outputs, stage A at bit 0 |

## Verification
The assertions assume that `count_up` changes only while a force pin is high. A direction flip during counting would swap a stage clock between true and inverted and could add a ripple edge that no step rule predicts. They also assume a force pin is pulsed at least once before counting starts, and they stay disarmed until then. The stimulus changes the force and direction pins one time unit after a falling clock edge, and changes direction only while `preset_all` is held. The one exception is a release placed inside a high phase, which exercises R7.

// File: rtl/ripple_pkg.sv
package ripple_pkg;

  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } dir_e;

endpackage

// File: rtl/rudc_toggle_stage.sv
module rudc_toggle_stage (
  input  logic clk_i,
  input  logic clr_i,
  input  logic set_i,
  output logic q_o
);

  // D fed from its own inverse: toggle on each rising edge; clear beats set
  always_ff @(posedge clk_i or posedge clr_i or posedge set_i) begin
    if (clr_i)      q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else            q_o <= ~q_o;
  end

endmodule

// File: rtl/rudc_clock_gate.sv
module rudc_clock_gate (
  input  logic clk_i,
  input  logic hold_i,
  output logic gclk_o
);

  logic pass_lat;

  // enable captured only while the clock is low, so no partial pulse escapes
  always_latch begin
    if (!clk_i) pass_lat = ~hold_i;
  end

  assign gclk_o = clk_i & pass_lat & ~hold_i;

endmodule

// File: rtl/rudc_stage_clk_sel.sv
module rudc_stage_clk_sel
  import ripple_pkg::*;
(
  input  logic q_prev_i,
  input  dir_e dir_i,
  output logic sclk_o
);

  // up: next stage steps when previous falls (inverted feed); down: when it rises
  always_comb begin
    unique case (dir_i)
      DIR_UP:   sclk_o = ~q_prev_i;
      default:  sclk_o = q_prev_i;
    endcase
  end

endmodule

// File: rtl/ripple_updown_counter.sv
module ripple_updown_counter
  import ripple_pkg::*;
#(
  parameter int STAGES = 3
) (
  input  logic              clk_in,
  input  logic              count_up,
  input  logic              clear_all,
  input  logic              preset_all,
  output logic [STAGES-1:0] count_q
);

  localparam int LAST = STAGES - 1;

  logic              hold_any;
  logic              set_eff;
  logic              gclk;
  logic [STAGES-1:0] stage_clk;
  logic [STAGES-1:0] stage_q;
  dir_e              dir;

  assign hold_any = clear_all | preset_all;
  // set only when clear is absent: a falling clear then re-applies the set
  assign set_eff  = preset_all & ~clear_all;
  assign dir      = dir_e'(count_up);

  rudc_clock_gate u_gate (
    .clk_i  (clk_in),
    .hold_i (hold_any),
    .gclk_o (gclk)
  );

  assign stage_clk[0] = gclk;

  generate
    for (genvar s = 1; s <= LAST; s++) begin : g_sel
      rudc_stage_clk_sel u_sel (
        .q_prev_i (stage_q[s-1]),
        .dir_i    (dir),
        .sclk_o   (stage_clk[s])
      );
    end
    for (genvar s = 0; s <= LAST; s++) begin : g_stage
      rudc_toggle_stage u_stage (
        .clk_i (stage_clk[s]),
        .clr_i (clear_all),
        .set_i (set_eff),
        .q_o   (stage_q[s])
      );
    end
  endgenerate

  assign count_q = stage_q;

endmodule

// File: rtl/ripple_updown_counter_chk.sv
module ripple_updown_counter_chk #(
  parameter int STAGES = 3
) (
  input logic              clk_in,
  input logic              count_up,
  input logic              clear_all,
  input logic              preset_all,
  input logic [STAGES-1:0] count_q
);

  localparam logic [STAGES-1:0] ALL_ONES = {STAGES{1'b1}};

  logic armed = 1'b0;

  always_ff @(posedge clk_in or posedge clear_all) begin
    if (clear_all) armed <= 1'b1;
  end

  // R1 and R3: clear reads zero regardless of preset
  p_clear_zero_r1: assert property (@(posedge clk_in) disable iff (!armed)
    clear_all |-> count_q == '0);

  // R2
  p_preset_ones_r2: assert property (@(posedge clk_in) disable iff (!armed)
    (preset_all && !clear_all) |-> count_q == ALL_ONES);

  // R6
  p_hold_stable_r6: assert property (@(posedge clk_in) disable iff (!armed)
    ((clear_all || preset_all) && $past(clear_all || preset_all)
     && $stable(clear_all) && $stable(preset_all)) |-> $stable(count_q));

  // R4
  p_step_up_r4: assert property (@(posedge clk_in)
    disable iff (!armed || clear_all || preset_all)
    count_up |=> count_q == STAGES'($past(count_q) + 1'b1));

  // R5
  p_step_down_r5: assert property (@(posedge clk_in)
    disable iff (!armed || clear_all || preset_all)
    !count_up |=> count_q == STAGES'($past(count_q) - 1'b1));

  // input rule: direction moves only under a force
  p_dir_steady_r4: assert property (@(posedge clk_in)
    disable iff (!armed || clear_all || preset_all)
    1'b1 |-> $stable(count_up));

endmodule

bind ripple_updown_counter ripple_updown_counter_chk #(.STAGES(STAGES)) u_chk (
  .clk_in     (clk_in),
  .count_up   (count_up),
  .clear_all  (clear_all),
  .preset_all (preset_all),
  .count_q    (count_q)
);

// File: tb/ripple_updown_counter_test.sv
module ripple_updown_counter_test;

  localparam int W = 3;

  logic         clk = 1'b0;
  logic         count_up = 1'b1;
  logic         clear_all = 1'b0;
  logic         preset_all = 1'b0;
  logic [W-1:0] count_q;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] model = '0;
  logic [W-1:0] exp_q[$];
  string        tag_q[$];
  bit           done = 1'b0;

  always #5 clk = ~clk;

  ripple_updown_counter #(.STAGES(W)) uut (
    .clk_in     (clk),
    .count_up   (count_up),
    .clear_all  (clear_all),
    .preset_all (preset_all),
    .count_q    (count_q)
  );

  task automatic check_now(input string req, input logic [W-1:0] exp);
    checks++;
    if (count_q !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, count_q, exp);
    end
  endtask

  // driver: one clock step per call, expected value pushed to the scoreboard
  task automatic drive_steps(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      model = count_up ? model + 1'b1 : model - 1'b1;
      exp_q.push_back(model);
      tag_q.push_back(req);
    end
  endtask

  task automatic after_fall();
    @(negedge clk);
    #1;
  endtask

  // monitor: compare mid low phase, after ripple settles
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [W-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (count_q !== e) begin
        errors++;
        $display("FAIL %s actual %0d expected %0d", t, count_q, e);
      end
    end
  end

  initial begin
    #2 clear_all = 1'b1;
    #1 check_now("R1", 3'd0);
    after_fall();
    check_now("R6", 3'd0);
    clear_all = 1'b0;
    model = '0;
    // R4: up through wrap 7 -> 0
    drive_steps(10, "R4");
    after_fall();
    preset_all = 1'b1;
    #1 check_now("R2", 3'd7);
    count_up = 1'b0;
    repeat (3) @(posedge clk);
    #2 check_now("R6", 3'd7);
    after_fall();
    clear_all = 1'b1;
    #1 check_now("R3", 3'd0);
    after_fall();
    check_now("R3", 3'd0);
    clear_all = 1'b0;
    #1 check_now("R8", 3'd7);
    after_fall();
    preset_all = 1'b0;
    model = 3'd7;
    // R5: down through wrap 0 -> 7
    drive_steps(10, "R5");
    after_fall();
    clear_all = 1'b1;
    @(posedge clk);
    #2 clear_all = 1'b0;
    @(negedge clk);
    #1 check_now("R7", 3'd0);
    model = '0;
    drive_steps(2, "R7");
    after_fall();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        #100000;
        checks++;
        errors++;
        $display("FAIL watchdog actual hung expected done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule